// File: doc/BRIEF.md
# Interleaving Cycle Thread Selector

This block decides which hardware thread issues into an interleaved multithreaded pipeline on every clock. A programmable slot table holds one thread identifier, or an idle code, per issue slot. While issue is enabled, the selector walks the table one slot per clock, wrapping after a programmable length. It presents the selected thread id and a valid flag, which fetch uses to pick that thread's private program counter, register-file bank and stack. An idle slot issues a bubble.

The table contents come from an offline scheduling step that sizes each thread's share of slots from its required issue rate. Software loads the slots and the length only while issue is disabled. Every new enable starts the walk at slot 0. A spacing checker watches the loaded table at all times. It raises an error flag when any thread would have two consecutive instructions fewer than a configured minimum number of slots apart, counting around the wrap. That minimum matches the pipeline depth needed to avoid data and control hazards between a thread's own instructions.

Top module: `icr_thread_selector`

## Requirements
- R1: After reset, issue_valid, issue_tid and spacing_err are 0, every slot holds the idle code, and the length is N_SLOTS.
- R2: While issue_en is low, nothing issues and issue_valid is 0. On the first clock edge that samples issue_en high, the outputs take the contents of slot 0.
- R3: On each later clock with issue_en high, the outputs present the next slot. After slot length-1 they return to slot 0.
- R4: A slot entry is TW+1 bits wide. Bits [TW-1:0] carry the thread id and bit TW is the idle flag. An entry with the idle flag set issues with issue_valid 0 and issue_tid 0. Any other entry issues with issue_valid 1 and issue_tid equal to its id.
- R5: Slot writes and length writes presented while issue_en is high are ignored.
- R6: A length write of 0 or of more than N_SLOTS is ignored.
- R7: spacing_err is 1 exactly when, among slots 0 to length-1, some non-idle thread has two occurrences whose cyclic distance is less than MIN_DIST. A thread that appears once in a table shorter than MIN_DIST also counts. The flag is registered and follows a table or length change within two clocks.
- R8: Disabling issue and then enabling it again restarts the walk at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_en | input | 1 | Enables the slot walk; low allows table loading |
| slot_we | input | 1 | Slot write strobe |
| slot_addr | input | SW | Slot index to write |
| slot_data | input | TW+1 | Entry: idle flag in bit TW, thread id below |
| len_we | input | 1 | Length write strobe |
| len_data | input | LW | New cycle length, 1 to N_SLOTS |
| issue_tid | output | TW | Thread id issued this cycle |
| issue_valid | output | 1 | A real thread issues this cycle |
| spacing_err | output | 1 | Loaded table breaks the minimum same-thread distance |

## Verification
A corrupted slot pointer shows on the next issued id, because each enabled clock exposes exactly one table entry. A wrong wrap shows within one pass of the programmed length, and a stale start shows on the first issued id after re-enable. A write that slips through while issue is enabled changes the sequence on the following pass. A wrong checker term shows on spacing_err two clocks after the offending table is loaded.

// File: rtl/icr_thread_selector.sv
module icr_thread_selector #(
  parameter int N_THREADS = 4,
  parameter int N_SLOTS   = 8,
  parameter int MIN_DIST  = 3,
  localparam int TW = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int EW = TW + 1,
  localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int LW = $clog2(N_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_en,
  input  logic          slot_we,
  input  logic [SW-1:0] slot_addr,
  input  logic [EW-1:0] slot_data,
  input  logic          len_we,
  input  logic [LW-1:0] len_data,
  output logic [TW-1:0] issue_tid,
  output logic          issue_valid,
  output logic          spacing_err
);

  localparam logic [EW-1:0] IDLE = EW'(1) << TW;

  logic [EW-1:0] tbl [N_SLOTS];
  logic [LW-1:0] len_q;
  logic [SW-1:0] ptr;
  logic [EW-1:0] cur;
  logic          last_slot;
  logic          err_c;

  assign cur       = tbl[ptr];
  assign last_slot = (LW'(ptr) == len_q - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) tbl[i] <= IDLE;
      len_q       <= LW'(N_SLOTS);
      ptr         <= '0;
      issue_tid   <= '0;
      issue_valid <= 1'b0;
      spacing_err <= 1'b0;
    end else begin
      spacing_err <= err_c;
      if (!issue_en) begin
        ptr         <= '0;
        issue_valid <= 1'b0;
        issue_tid   <= '0;
        if (slot_we && (int'(slot_addr) < N_SLOTS)) tbl[slot_addr] <= slot_data;
        if (len_we && (len_data != '0) && (int'(len_data) <= N_SLOTS)) len_q <= len_data;
      end else begin
        issue_valid <= ~cur[TW];
        issue_tid   <= cur[TW] ? '0 : cur[TW-1:0];
        ptr         <= last_slot ? '0 : ptr + SW'(1);
      end
    end
  end

  always_comb begin
    err_c = 1'b0;
    for (int i = 0; i < N_SLOTS; i++) begin
      for (int k = 1; k < MIN_DIST; k++) begin
        int j;
        j = (i + k) % int'(len_q);
        if ((i < int'(len_q)) && !tbl[i][TW] && (tbl[j] == tbl[i])) err_c = 1'b1;
      end
    end
  end

  assert_valid_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> $past(issue_en));

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_en) && ($past(LW'(ptr)) == $past(len_q) - LW'(1))) |-> (ptr == '0));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_en) && ($past(LW'(ptr)) != $past(len_q) - LW'(1))) |-> (ptr == $past(ptr) + SW'(1)));

  assert_idle_tid_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (issue_tid == '0));

  assert_len_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_en) |-> $stable(len_q));

  assert_len_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) && (int'(len_q) <= N_SLOTS));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(issue_en) |-> (ptr == '0));

endmodule

// File: tb/test_icr_thread_selector.sv
module test_icr_thread_selector;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4, NS = 8, MD = 3;
  localparam int TW = 2, EW = 3, SW = 3, LW = 4;
  localparam logic [EW-1:0] IDLE = 3'b100;

  logic clk = 0, rst_n = 0, issue_en = 0, slot_we = 0, len_we = 0;
  logic [SW-1:0] slot_addr = '0;
  logic [EW-1:0] slot_data = '0;
  logic [LW-1:0] len_data = '0;
  logic [TW-1:0] issue_tid;
  logic issue_valid, spacing_err;

  icr_thread_selector #(.N_THREADS(NT), .N_SLOTS(NS), .MIN_DIST(MD)) i_icr_thread_selector (
    .clk(clk), .rst_n(rst_n), .issue_en(issue_en), .slot_we(slot_we), .slot_addr(slot_addr),
    .slot_data(slot_data), .len_we(len_we), .len_data(len_data), .issue_tid(issue_tid),
    .issue_valid(issue_valid), .spacing_err(spacing_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [EW-1:0] m_tbl [NS];
  int m_len = NS;
  logic [TW:0] exp_q [$];
  string cur_req = "R1";

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [TW:0] e;
      e = exp_q.pop_front();
      check(cur_req, int'({issue_valid, issue_tid}), int'(e));
    end
  end

  function automatic bit model_err();
    bit e = 0;
    for (int i = 0; i < m_len; i++)
      for (int j = 0; j < m_len; j++)
        if (!m_tbl[i][TW] && m_tbl[i] == m_tbl[j]) begin
          int d = (j - i + m_len) % m_len;
          if (d == 0) d = m_len;
          if (d < MD) e = 1;
        end
    return e;
  endfunction

  task automatic wr_slot(int a, logic [EW-1:0] d);
    @(posedge clk); #1 slot_we = 1; slot_addr = SW'(a); slot_data = d;
    @(posedge clk); #1 slot_we = 0;
    m_tbl[a] = d;
  endtask

  task automatic wr_len(int v);
    @(posedge clk); #1 len_we = 1; len_data = LW'(v);
    @(posedge clk); #1 len_we = 0;
    if (v != 0 && v <= NS) m_len = v;
  endtask

  task automatic chk_err(string req);
    repeat (3) @(posedge clk);
    #1 check(req, int'(spacing_err), int'(model_err()));
  endtask

  task automatic run(string req, int n, bit poke);
    cur_req = req;
    @(posedge clk); #1 issue_en = 1;
    @(posedge clk); #1;
    for (int k = 0; k < n; k++) begin
      logic [EW-1:0] e;
      e = m_tbl[k % m_len];
      exp_q.push_back(e[TW] ? {1'b0, {TW{1'b0}}} : {1'b1, e[TW-1:0]});
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (poke && k == 1) begin
        slot_we = 1; slot_addr = '0; slot_data = 3'b011; len_we = 1; len_data = 4'd2;
      end
      if (poke && k == 2) begin slot_we = 0; len_we = 0; end
    end
    #1 issue_en = 0; slot_we = 0; len_we = 0;
    @(negedge clk);
    check({req, " R2 disabled"}, int'(issue_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) m_tbl[i] = IDLE;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 valid", int'(issue_valid), 0);
    check("R1 tid", int'(issue_tid), 0);
    check("R1 err", int'(spacing_err), 0);
    run("R1 R4 idle table", 5, 0);
    for (int i = 0; i < 6; i++) wr_slot(i, EW'(i % 3));
    wr_len(6);
    chk_err("R7 legal spacing");
    run("R2 R3 wrap", 14, 0);
    run("R8 partial", 4, 0);
    run("R8 restart", 6, 0);
    wr_slot(2, IDLE); wr_slot(5, IDLE);
    chk_err("R7 idle ignored");
    run("R4 bubbles", 8, 0);
    run("R5 write while enabled", 8, 1);
    run("R5 table unchanged", 8, 0);
    wr_len(0); wr_len(9);
    run("R6 illegal length", 8, 0);
    wr_slot(0, 3'd0); wr_slot(1, 3'd1); wr_slot(2, 3'd0); wr_len(3);
    chk_err("R7 close pair");
    wr_slot(2, 3'd2); wr_slot(3, 3'd0); wr_len(4);
    chk_err("R7 wrap pair");
    wr_slot(1, IDLE); wr_len(2);
    chk_err("R7 alone short");
    wr_slot(2, IDLE); wr_len(3);
    chk_err("R7 alone ok");
    check("R7 expected clear", int'(spacing_err), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule